// File: doc/BRIEF.md
# Configurable Video Test Pattern Generator

This block sits in a display pipeline after a timing generator and can replace the incoming pixel stream with a synthetic test image. It follows the incoming data-enable, horizontal sync and vertical sync. It keeps two stepping walkers, one per axis, and builds an 8-bit generated value from them. Each colour channel then takes either that value or one of three fixed levels. All outputs are registered, so output video lags input video by exactly one clock cycle. The sync signals are always forwarded unchanged.

Both axes have the same structure. A 16-bit accumulator starts each frame at a programmed initial value. It grows by a programmed increment once per step region, and a step region is a programmed number of pixels (horizontal) or lines (vertical). The horizontal walker reloads at the start of every line from the line's starting value. The vertical walker advances that starting value once per vertical region. A per-axis mode turns the plain gradient into alternating inversion or into a grid of single-pixel lines. A per-axis repeat flag restarts the axis at a programmed midpoint, so the pattern appears twice.

A small state machine follows the frame. `PG_SEEK` is entered at reset: no frame start has been seen, and no pattern is produced. Every vertical-sync rising edge, from any state, moves it to `PG_BLANK`, the gap between lines. A data-enable high in `PG_BLANK` moves it to `PG_ACTIVE`. A data-enable low in `PG_ACTIVE` marks the end of a line and returns it to `PG_BLANK`.

Top module: `test_pattern_gen`

## Requirements
- R1: `out_de`, `out_hs` and `out_vs` equal `in_de`, `in_hs` and `in_vs` of the previous clock cycle, whatever the configuration.
- R2: With both modes at 0 (gradient), the generated value for pixel h of active line v is bits 15:8 of `init_val + (v/(v_step_m1+1))*v_inc + (h/(h_step_m1+1))*h_inc`, taken modulo 2^16. Lines and pixels are counted from 0, from the vertical-sync rising edge and from the data-enable rising edge.
- R3: The step fields hold n-1. A value of 0 advances the accumulator on every pixel or line, and a value of k advances it once every k+1 pixels or lines.
- R4: Mode 1 (inversion) on an axis complements the generated value in every odd-numbered step region of that axis. When both axes are in mode 1, the two complements cancel.
- R5: Mode 2 or 3 (line) on either axis makes the generated value 0xFF on the first pixel (or line) of each step region of every axis in line mode, and 0x00 elsewhere.
- R6: With `h_rep2` (or `v_rep2`) set, pixel index `h_mid_pos` (or line index `v_mid_pos`) restarts that axis as if it were index 0.
- R7: `col_sel[1:0]` chooses blue (out_rgb[7:0]), `col_sel[3:2]` green (out_rgb[15:8]) and `col_sel[5:4]` red (out_rgb[23:16]). The codes are 0 for the generated value, 1 for 0x00, 2 for 0x80 and 3 for 0xFF.
- R8: With `pg_en` low, `out_rgb` equals `in_rgb` of the previous cycle.
- R9: With `pg_en` high, `out_rgb` is zero for every cycle in which `in_de` was low.
- R10: With `pg_en` high, data-enable cycles that come before the first vertical-sync rising edge after reset give `out_rgb` equal to zero.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_en | input | 1 | 1 = output the pattern, 0 = pass input video through |
| h_mode | input | 2 | Horizontal mode: 0 gradient, 1 inversion, 2/3 line |
| v_mode | input | 2 | Vertical mode: 0 gradient, 1 inversion, 2/3 line |
| h_rep2 | input | 1 | Restart the horizontal axis at `h_mid_pos` |
| v_rep2 | input | 1 | Restart the vertical axis at `v_mid_pos` |
| init_val | input | 16 | Accumulator value at frame start |
| h_inc | input | 16 | Added per horizontal step region |
| v_inc | input | 16 | Added per vertical step region |
| h_step_m1 | input | 8 | Pixels per horizontal region, minus one |
| v_step_m1 | input | 8 | Lines per vertical region, minus one |
| col_sel | input | 6 | Per-channel source select, 2 bits each (B, G, R from LSB) |
| h_mid_pos | input | 12 | Pixel index where horizontal repetition restarts |
| v_mid_pos | input | 12 | Line index where vertical repetition restarts |
| in_de | input | 1 | Incoming data enable |
| in_hs | input | 1 | Incoming horizontal sync |
| in_vs | input | 1 | Incoming vertical sync (frame starts on rising edge) |
| in_rgb | input | 24 | Incoming pixel, R in 23:16, G in 15:8, B in 7:0 |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_rgb | output | 24 | Pattern pixel or passed-through pixel |

## Verification
The hardest situations to reach are where region boundaries meet the repetition midpoint. One case is an odd step length that does not divide the midpoint, so the restart cuts a region short. Another is an accumulator that wraps past 0xFFFF within a line. These only show up in full frames of chosen geometry. The stimulus therefore drives whole frames with small random widths, heights, step lengths, increments and midpoints, which places many boundaries and wraps inside each frame. Directed frames cover a step length of zero, a step longer than the line, an odd width with repetition, and data-enable pulses before the first frame start.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        PG_SEEK   = 2'd0,
        PG_BLANK  = 2'd1,
        PG_ACTIVE = 2'd2
    } pg_state_e;

    localparam logic [1:0] MODE_GRAD = 2'd0;
    localparam logic [1:0] MODE_INV  = 2'd1;

    localparam logic [1:0] SRC_GEN   = 2'd0;
    localparam logic [1:0] SRC_ZERO  = 2'd1;
    localparam logic [1:0] SRC_MID   = 2'd2;
    localparam logic [1:0] SRC_FULL  = 2'd3;

    function automatic logic mode_is_line(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/pg_walker.sv
module pg_walker #(
    parameter int VAL_W  = 16,
    parameter int STEP_W = 8,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [VAL_W-1:0]  load_val,
    input  logic [VAL_W-1:0]  inc,
    input  logic [STEP_W-1:0] step_m1,
    output logic [STEP_W-1:0] cur_phase,
    output logic              cur_odd,
    output logic [OUT_W-1:0]  cur_top
);

    logic [STEP_W-1:0] phase_q;
    logic              odd_q;
    logic [VAL_W-1:0]  acc_q;
    logic [VAL_W-1:0]  cur_acc;

    always_comb begin
        if (load) begin
            cur_phase = '0;
            cur_odd   = 1'b0;
            cur_acc   = load_val;
        end else begin
            cur_phase = phase_q;
            cur_odd   = odd_q;
            cur_acc   = acc_q;
        end
    end

    assign cur_top = cur_acc[VAL_W-1 -: OUT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            odd_q   <= 1'b0;
            acc_q   <= '0;
        end else if (adv) begin
            if (cur_phase == step_m1) begin
                phase_q <= '0;
                odd_q   <= ~cur_odd;
                acc_q   <= cur_acc + inc;
            end else begin
                phase_q <= cur_phase + 1'b1;
                odd_q   <= cur_odd;
                acc_q   <= cur_acc;
            end
        end else if (load) begin
            phase_q <= '0;
            odd_q   <= 1'b0;
            acc_q   <= load_val;
        end
    end

endmodule

// File: rtl/pg_shaper.sv
module pg_shaper
    import pg_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int STEP_W = 8
) (
    input  logic [CH_W-1:0]   h_top,
    input  logic [STEP_W-1:0] h_phase,
    input  logic              h_odd,
    input  logic [STEP_W-1:0] v_phase,
    input  logic              v_odd,
    input  logic [1:0]        h_mode,
    input  logic [1:0]        v_mode,
    input  logic [5:0]        col_sel,
    output logic [3*CH_W-1:0] rgb
);

    localparam logic [CH_W-1:0] LVL_MID = CH_W'(1) << (CH_W - 1);

    logic            line_any;
    logic            line_hit;
    logic            flip;
    logic [CH_W-1:0] gen;

    always_comb begin
        line_any = mode_is_line(h_mode) | mode_is_line(v_mode);
        line_hit = (mode_is_line(h_mode) && (h_phase == '0)) ||
                   (mode_is_line(v_mode) && (v_phase == '0));
        flip     = ((v_mode == MODE_INV) & v_odd) ^ ((h_mode == MODE_INV) & h_odd);
        if (line_any) begin
            gen = line_hit ? '1 : '0;
        end else begin
            gen = h_top ^ {CH_W{flip}};
        end
    end

    for (genvar c = 0; c < 3; c++) begin : g_chan
        always_comb begin
            unique case (col_sel[2*c +: 2])
                SRC_GEN:  rgb[c*CH_W +: CH_W] = gen;
                SRC_ZERO: rgb[c*CH_W +: CH_W] = '0;
                SRC_MID:  rgb[c*CH_W +: CH_W] = LVL_MID;
                SRC_FULL: rgb[c*CH_W +: CH_W] = '1;
                default:  rgb[c*CH_W +: CH_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
    import pg_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int STEP_W = 8,
    parameter int POS_W  = 12,
    parameter int CH_W   = 8,
    localparam int RGB_W = 3 * CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_en,
    input  logic [1:0]        h_mode,
    input  logic [1:0]        v_mode,
    input  logic              h_rep2,
    input  logic              v_rep2,
    input  logic [ACC_W-1:0]  init_val,
    input  logic [ACC_W-1:0]  h_inc,
    input  logic [ACC_W-1:0]  v_inc,
    input  logic [STEP_W-1:0] h_step_m1,
    input  logic [STEP_W-1:0] v_step_m1,
    input  logic [5:0]        col_sel,
    input  logic [POS_W-1:0]  h_mid_pos,
    input  logic [POS_W-1:0]  v_mid_pos,
    input  logic              in_de,
    input  logic              in_hs,
    input  logic              in_vs,
    input  logic [RGB_W-1:0]  in_rgb,
    output logic              out_de,
    output logic              out_hs,
    output logic              out_vs,
    output logic [RGB_W-1:0]  out_rgb
);

    pg_state_e state_q, state_d;
    logic      vs_d;
    logic      frame_start;

    assign frame_start = in_vs & ~vs_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_SEEK;
            vs_d    <= 1'b0;
        end else begin
            state_q <= state_d;
            vs_d    <= in_vs;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_SEEK:   if (frame_start) state_d = PG_BLANK;
            PG_BLANK:  if (frame_start) state_d = PG_BLANK;
                       else if (in_de)  state_d = PG_ACTIVE;
            PG_ACTIVE: if (frame_start || !in_de) state_d = PG_BLANK;
            default:   state_d = PG_SEEK;
        endcase
    end

    logic first_pix, pix_valid, line_end;
    assign first_pix = (state_q == PG_BLANK) & in_de & ~frame_start;
    assign pix_valid = first_pix | ((state_q == PG_ACTIVE) & in_de);
    assign line_end  = (state_q == PG_ACTIVE) & ~in_de;

    // horizontal position within the line
    logic [POS_W-1:0] hpos_q;
    logic             h_mid;
    logic             h_load;
    assign h_mid  = h_rep2 & (state_q == PG_ACTIVE) & in_de & (hpos_q == h_mid_pos);
    assign h_load = first_pix | h_mid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hpos_q <= '0;
        end else if (pix_valid) begin
            hpos_q <= (first_pix ? '0 : hpos_q) + POS_W'(1);
        end
    end

    // vertical position within the frame
    logic [POS_W-1:0] vline_q;
    logic [POS_W-1:0] v_nxt;
    logic             v_mid;
    logic             v_load;
    logic             v_adv;
    assign v_nxt  = vline_q + POS_W'(1);
    assign v_mid  = line_end & v_rep2 & (v_nxt == v_mid_pos) & ~frame_start;
    assign v_load = frame_start | v_mid;
    assign v_adv  = line_end & ~v_mid & ~frame_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vline_q <= '0;
        end else if (frame_start) begin
            vline_q <= '0;
        end else if (line_end) begin
            vline_q <= v_nxt;
        end
    end

    logic [ACC_W-1:0]  line_start;
    logic [STEP_W-1:0] v_phase;
    logic              v_odd;
    logic [STEP_W-1:0] h_phase;
    logic              h_odd;
    logic [CH_W-1:0]   h_top;
    logic [RGB_W-1:0]  pat_rgb;

    pg_walker #(.VAL_W(ACC_W), .STEP_W(STEP_W), .OUT_W(ACC_W)) v_walk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (v_load),
        .adv       (v_adv),
        .load_val  (init_val),
        .inc       (v_inc),
        .step_m1   (v_step_m1),
        .cur_phase (v_phase),
        .cur_odd   (v_odd),
        .cur_top   (line_start)
    );

    pg_walker #(.VAL_W(ACC_W), .STEP_W(STEP_W), .OUT_W(CH_W)) h_walk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (h_load),
        .adv       (pix_valid),
        .load_val  (line_start),
        .inc       (h_inc),
        .step_m1   (h_step_m1),
        .cur_phase (h_phase),
        .cur_odd   (h_odd),
        .cur_top   (h_top)
    );

    pg_shaper #(.CH_W(CH_W), .STEP_W(STEP_W)) shape_i (
        .h_top   (h_top),
        .h_phase (h_phase),
        .h_odd   (h_odd),
        .v_phase (v_phase),
        .v_odd   (v_odd),
        .h_mode  (h_mode),
        .v_mode  (v_mode),
        .col_sel (col_sel),
        .rgb     (pat_rgb)
    );

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_de  <= 1'b0;
            out_hs  <= 1'b0;
            out_vs  <= 1'b0;
            out_rgb <= '0;
        end else begin
            out_de  <= in_de;
            out_hs  <= in_hs;
            out_vs  <= in_vs;
            if (!pg_en) begin
                out_rgb <= in_rgb;
            end else if (pix_valid) begin
                out_rgb <= pat_rgb;
            end else begin
                out_rgb <= '0;
            end
        end
    end

endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
    parameter int RGB_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pg_en,
    input logic [5:0]       col_sel,
    input logic             in_de,
    input logic             in_hs,
    input logic             in_vs,
    input logic [RGB_W-1:0] in_rgb,
    input logic             out_de,
    input logic             out_hs,
    input logic             out_vs,
    input logic [RGB_W-1:0] out_rgb
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_de_delay: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_de == $past(in_de)));

    a_r1_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_hs == $past(in_hs)) && (out_vs == $past(in_vs)));

    a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(pg_en)) |-> (out_rgb == $past(in_rgb)));

    a_r9_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pg_en && !in_de)) |-> (out_rgb == '0));

    a_r7_blue_full: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pg_en && in_de && (col_sel[1:0] == 2'd3))) |-> (out_rgb[7:0] == 8'hFF));

    a_r7_red_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pg_en && in_de && (col_sel[5:4] == 2'd1))) |-> (out_rgb[23:16] == 8'h00));

endmodule

bind test_pattern_gen pg_checker #(.RGB_W(24)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pg_en   (pg_en),
    .col_sel (col_sel),
    .in_de   (in_de),
    .in_hs   (in_hs),
    .in_vs   (in_vs),
    .in_rgb  (in_rgb),
    .out_de  (out_de),
    .out_hs  (out_hs),
    .out_vs  (out_vs),
    .out_rgb (out_rgb)
);

// File: tb/test_pattern_gen_tb_top.sv
`timescale 1ns/1ps
module test_pattern_gen_tb_top;

    typedef struct packed {
        logic        en;
        logic [1:0]  hmode;
        logic [1:0]  vmode;
        logic        hrep;
        logic        vrep;
        logic [15:0] init;
        logic [15:0] hinc;
        logic [15:0] vinc;
        logic [7:0]  hstep;
        logic [7:0]  vstep;
        logic [5:0]  sel;
        logic [11:0] hmid;
        logic [11:0] vmid;
    } cfg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    cfg_t cfg, cfg_n;
    logic        de = 0, hs = 0, vs = 0;
    logic [23:0] rgb = '0;
    logic        o_de, o_hs, o_vs;
    logic [23:0] o_rgb;

    test_pattern_gen dut_i (
        .clk(clk), .rst_n(rst_n), .pg_en(cfg.en),
        .h_mode(cfg.hmode), .v_mode(cfg.vmode),
        .h_rep2(cfg.hrep), .v_rep2(cfg.vrep),
        .init_val(cfg.init), .h_inc(cfg.hinc), .v_inc(cfg.vinc),
        .h_step_m1(cfg.hstep), .v_step_m1(cfg.vstep),
        .col_sel(cfg.sel), .h_mid_pos(cfg.hmid), .v_mid_pos(cfg.vmid),
        .in_de(de), .in_hs(hs), .in_vs(vs), .in_rgb(rgb),
        .out_de(o_de), .out_hs(o_hs), .out_vs(o_vs), .out_rgb(o_rgb)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    bit m_frame = 0, m_pde = 0, m_pvs = 0;
    int m_h = 0, m_v = 0;
    bit          pend = 0;
    logic [2:0]  p_sync;
    logic [23:0] p_rgb;
    string       p_tag;

    function automatic logic [23:0] model_px(cfg_t c, int h, int v);
        int hp = (c.hrep && h >= int'(c.hmid)) ? h - int'(c.hmid) : h;
        int vp = (c.vrep && v >= int'(c.vmid)) ? v - int'(c.vmid) : v;
        int hr = hp / (int'(c.hstep) + 1);
        int hph = hp % (int'(c.hstep) + 1);
        int vr = vp / (int'(c.vstep) + 1);
        int vph = vp % (int'(c.vstep) + 1);
        logic [15:0] acc = 16'(int'(c.init) + vr * int'(c.vinc) + hr * int'(c.hinc));
        logic [7:0]  g;
        logic [23:0] r;
        if (c.hmode[1] || c.vmode[1]) begin
            g = ((c.hmode[1] && hph == 0) || (c.vmode[1] && vph == 0)) ? 8'hFF : 8'h00;
        end else begin
            logic inv = ((c.vmode == 2'd1) && (vr % 2 == 1)) ^ ((c.hmode == 2'd1) && (hr % 2 == 1));
            g = acc[15:8] ^ {8{inv}};
        end
        for (int ch = 0; ch < 3; ch++) begin
            case (c.sel[2*ch +: 2])
                2'd0: r[8*ch +: 8] = g;
                2'd1: r[8*ch +: 8] = 8'h00;
                2'd2: r[8*ch +: 8] = 8'h80;
                default: r[8*ch +: 8] = 8'hFF;
            endcase
        end
        return r;
    endfunction

    function automatic string tag_for(cfg_t c);
        if (c.hmode[1] || c.vmode[1]) return "R5";
        if (c.hmode == 2'd1 || c.vmode == 2'd1) return "R4";
        if (c.hrep || c.vrep) return "R6";
        if (c.sel != 6'd0) return "R7";
        if (c.hstep != 0 || c.vstep != 0) return "R3";
        return "R2";
    endfunction

    task automatic step(input logic d, input logic h, input logic v, input logic [23:0] px);
        @(negedge clk);
        if (pend && !done) begin
            n_chk++;
            if ({o_de, o_hs, o_vs} !== p_sync) begin
                n_bad++;
                $display("FAIL R1 sync act=%b exp=%b", {o_de, o_hs, o_vs}, p_sync);
            end
            n_chk++;
            if (o_rgb !== p_rgb) begin
                n_bad++;
                $display("FAIL %s rgb act=%h exp=%h", p_tag, o_rgb, p_rgb);
            end
        end
        cfg = cfg_n;
        if (v && !m_pvs) begin m_frame = 1; m_v = 0; end
        if (d && !m_pde) m_h = 0;
        p_sync = {d, h, v};
        if (!cfg.en) begin
            p_rgb = px; p_tag = "R8";
        end else if (d && m_frame) begin
            p_rgb = model_px(cfg, m_h, m_v); p_tag = tag_for(cfg);
        end else if (d) begin
            p_rgb = '0; p_tag = "R10";
        end else begin
            p_rgb = '0; p_tag = "R9";
        end
        if (d) m_h++;
        if (!d && m_pde && m_frame) m_v++;
        m_pde = d; m_pvs = v;
        pend = 1;
        de = d; hs = h; vs = v; rgb = px;
    endtask

    task automatic frame(input int w, input int lines);
        step(0, 0, 1, 24'h0); step(0, 0, 1, 24'h0);
        step(0, 0, 0, 24'h0); step(0, 0, 0, 24'h0);
        for (int l = 0; l < lines; l++) begin
            step(0, 1, 0, 24'h0); step(0, 0, 0, 24'h0); step(0, 0, 0, 24'h0);
            for (int p = 0; p < w; p++) step(1, 0, 0, 24'($urandom));
        end
        step(0, 0, 0, 24'h0); step(0, 0, 0, 24'h0);
    endtask

    function automatic cfg_t base_cfg(int w, int lines);
        cfg_t c = '0;
        c.en = 1; c.init = 16'h1000; c.hinc = 16'h0800; c.vinc = 16'h2000;
        c.hmid = 12'(w / 2); c.vmid = 12'(lines / 2);
        return c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cfg_t c;
        void'($urandom(32'h5EED_0042));
        cfg_n = '0; cfg = '0;
        de = 1; hs = 1; vs = 0; rgb = 24'hABCDEF;
        repeat (3) @(negedge clk);
        // R11: outputs held at zero during reset
        n_chk++;
        if ({o_de, o_hs, o_vs, o_rgb} !== '0) begin
            n_bad++;
            $display("FAIL R11 reset act=%h exp=0", {o_de, o_hs, o_vs, o_rgb});
        end
        de = 0; hs = 0; rgb = '0;
        @(negedge clk); rst_n = 1;
        // R10: DE before any frame start with pattern on
        cfg_n = base_cfg(8, 4);
        for (int i = 0; i < 6; i++) step(1, 0, 0, 24'h123456);
        step(0, 0, 0, 0);
        // R2: plain gradient, step 0
        frame(8, 4);
        // R3: step length longer than one, odd and beyond line width
        c = base_cfg(10, 6); c.hstep = 8'd2; c.vstep = 8'd1; cfg_n = c; frame(10, 6);
        c.hstep = 8'd40; cfg_n = c; frame(10, 3);
        // wrap of the accumulator within a line (R2)
        c = base_cfg(12, 3); c.init = 16'hF000; c.hinc = 16'h0700; cfg_n = c; frame(12, 3);
        // R4: inversion on each axis and both
        c = base_cfg(9, 6); c.hmode = 2'd1; c.hstep = 8'd1; cfg_n = c; frame(9, 6);
        c.vmode = 2'd1; cfg_n = c; frame(9, 6);
        // R5: line modes, codes 2 and 3
        c = base_cfg(10, 7); c.hmode = 2'd2; c.hstep = 8'd2; c.vmode = 2'd3; c.vstep = 8'd2; cfg_n = c; frame(10, 7);
        // R6: repetition with odd width and odd step
        c = base_cfg(9, 7); c.hrep = 1; c.vrep = 1; c.hstep = 8'd2; c.vstep = 8'd1; cfg_n = c; frame(9, 7);
        // R7: every constant code on the channels
        c = base_cfg(6, 3); c.sel = 6'b11_10_01; cfg_n = c; frame(6, 3);
        c.sel = 6'b00_11_10; cfg_n = c; frame(6, 3);
        // R8: pass-through
        c.en = 0; cfg_n = c; frame(7, 3);
        // random frames
        for (int f = 0; f < 24; f++) begin
            int w = 2 + int'($urandom % 19);
            int l = 2 + int'($urandom % 9);
            c = base_cfg(w, l);
            c.en = ($urandom % 8) != 0;
            c.hmode = 2'($urandom); c.vmode = 2'($urandom);
            c.hrep = 1'($urandom); c.vrep = 1'($urandom);
            c.init = 16'($urandom); c.hinc = 16'($urandom); c.vinc = 16'($urandom);
            c.hstep = 8'($urandom % 5); c.vstep = 8'($urandom % 4);
            c.sel = ($urandom % 2) ? 6'($urandom) : 6'd0;
            cfg_n = c;
            frame(w, l);
        end
        step(0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule